// File: doc/BRIEF.md
# Chained-Descriptor Transmit DMA Engine

This block moves outgoing frames from memory to a byte stream. Software builds four-word descriptors in memory and hands them over by setting an ownership flag. When the engine is told to start, it reads the descriptor at a programmed base address. It then reads the referenced buffer one word at a time and presents the bytes on a valid/ready stream, with markers for the first and last byte. It writes a completion status back to the descriptor and then moves on to the next descriptor, either through an explicit link pointer or by stepping to the adjacent slot. If it reads a descriptor that software still owns, it parks in a suspended state until software issues a poll demand.

The memory side is a word-wide request port. A request is held with its address, direction and write data unchanged until `mem_ready` is seen high. Read data is taken in the same cycle that `mem_ready` is high. On the byte stream, a byte is transferred on every clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the offered byte and its markers stay unchanged. The only exception is a flush, which withdraws the byte. A small byte queue separates the memory reads from the consumer, so a consumer that stalls only holds up buffer reads once the queue is full.

Top module: `txdesc_dma`

## Requirements
- R1: Out of reset, `dma_state` reads 0 (stopped), `mem_req`, `tx_valid` and `flush_busy` are low, and the engine stays stopped until `start_req` is seen.
- R2: `start_req` in the stopped state makes the engine read word 0 of the descriptor at `desc_base`. If bit 31 (own, 1 = engine owns it) of that word is 0, the engine reads nothing else, writes nothing, streams nothing, and `dma_state` becomes 6 (suspended).
- R3: For an owned descriptor, the engine streams exactly the number of bytes given in word 1 bits 10:0. Word 2 is the buffer byte address (word aligned). Byte k comes from buffer address + k, and byte 0 of a memory word is its bits 7:0. The offered byte is held stable while `tx_ready` is low.
- R4: `tx_first` marks byte 0 of a descriptor only when word 1 bit 29 is set. `tx_last` marks its final byte only when word 1 bit 30 is set. Word 1 bits 28:27 have no effect on the stream.
- R5: After the last byte is queued, the engine writes word 0 twice. The first write has bit 31 = 1 and the byte count in bits 10:0. It is then immediately followed by a write to the same address with bit 31 = 0 and the same count.
- R6: After the write-back, the next descriptor address is word 3 if word 1 bit 24 (chained) is set, and the current address + 16 otherwise. A descriptor linked to itself is fetched again.
- R7: `poll_req` in the suspended state re-reads the descriptor that caused the suspension. Without a poll, the suspended state is kept.
- R8: `start_req` and `poll_req` have no effect while the engine is fetching, streaming or writing back. `start_req` also has no effect in the suspended state.
- R9: A descriptor with size 0 streams no byte but is still written back and followed as in R5 and R6.
- R10: `flush_req` discards every byte queued for the stream. `tx_valid` is low and `flush_busy` is high in the cycle after the request, and `flush_busy` reads 0 again one cycle later.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until it is accepted with `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start_req | input | 1 | One-cycle request to leave the stopped state |
| poll_req | input | 1 | One-cycle poll demand to leave the suspended state |
| flush_req | input | 1 | One-cycle request to empty the byte queue |
| desc_base | input | ADDR_W | Byte address of the first descriptor |
| dma_state | output | 3 | Engine state: 0 stopped, 6 suspended, other values running |
| flush_busy | output | 1 | High in the cycle after a flush request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream consumer ready |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a descriptor with the first flag |
| tx_last | output | 1 | Final byte of a descriptor with the last flag |

## Verification
The results of a start or poll request appear one cycle later: the state leaves 0 or 6 on the next edge. The flush result appears one cycle later as well: `flush_busy` is high and `tx_valid` is low in the cycle after the request, and `flush_busy` is back at 0 in the following cycle. The bench samples these at the falling edge of the cycle in which they are due. Stream bytes and memory writes have no fixed latency, because both ports are stalled by a pseudo-random pattern. For these, the bench keeps ordered queues of the expected bytes (with markers) and the expected writes, built from the descriptors it places in memory. On every clock it compares each accepted byte and each accepted write against the head of the matching queue.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RDBUF = 3'd3,
    ST_PUSH  = 3'd4,
    ST_SUSP  = 3'd6,
    ST_CLOSE = 3'd7
  } dma_state_e;

  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int FIRST_BIT = 29;
  localparam int CHAIN_BIT = 24;
  localparam int SIZE_W    = 11;
  localparam int WORD_W    = 32;

  typedef struct packed {
    logic       first;
    logic       last;
    logic [7:0] data;
  } tx_byte_t;

endpackage

// File: rtl/txdma_byte_fifo.sv
module txdma_byte_fifo
  import txdma_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     in_valid,
  input  tx_byte_t in_byte,
  output logic     in_room,
  output logic     out_valid,
  output tx_byte_t out_byte,
  input  logic     out_ready
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  tx_byte_t        slots [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic            do_push, do_pop;

  assign in_room   = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_byte  = slots[rd_ptr];
  assign do_push   = in_valid && in_room && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/txdma_desc_engine.sv
module txdma_desc_engine
  import txdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DESC_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              poll_req,
  input  logic [ADDR_W-1:0] desc_base,
  output dma_state_e        state_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              push_valid,
  output tx_byte_t          push_byte,
  input  logic              push_room
);

  localparam int PAD_W = WORD_W - 1 - SIZE_W;

  dma_state_e        state;
  logic [ADDR_W-1:0] cur_addr, buf_ptr, next_ptr;
  logic [1:0]        idx;
  logic [SIZE_W-1:0] size_q, byte_left;
  logic              chain_q, first_q, last_q, first_pend;
  logic [WORD_W-1:0] word_buf;
  logic [1:0]        byte_sel;

  assign state_o = state;

  always_comb begin
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_addr;
    mem_wdata  = '0;
    push_valid = 1'b0;
    push_byte  = '{first: first_pend,
                   last:  last_q && (byte_left == SIZE_W'(1)),
                   data:  word_buf[{byte_sel, 3'b000} +: 8]};
    case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + ADDR_W'({idx, 2'b00});
      end
      ST_RDBUF: begin
        mem_req  = 1'b1;
        mem_addr = buf_ptr;
      end
      ST_PUSH:  push_valid = 1'b1;
      ST_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {(idx == 2'd0), {PAD_W{1'b0}}, size_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_STOP;
      cur_addr   <= '0;
      buf_ptr    <= '0;
      next_ptr   <= '0;
      idx        <= '0;
      size_q     <= '0;
      byte_left  <= '0;
      chain_q    <= 1'b0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
      first_pend <= 1'b0;
      word_buf   <= '0;
      byte_sel   <= '0;
    end else begin
      case (state)
        ST_STOP: if (start_req) begin
          cur_addr <= desc_base;
          idx      <= '0;
          state    <= ST_FETCH;
        end
        ST_SUSP: if (poll_req) begin
          idx   <= '0;
          state <= ST_FETCH;
        end
        ST_FETCH: if (mem_ready) begin
          idx <= idx + 1'b1;
          case (idx)
            2'd0: if (!mem_rdata[OWN_BIT]) begin
              idx   <= '0;
              state <= ST_SUSP;
            end
            2'd1: begin
              size_q  <= mem_rdata[SIZE_W-1:0];
              chain_q <= mem_rdata[CHAIN_BIT];
              first_q <= mem_rdata[FIRST_BIT];
              last_q  <= mem_rdata[LAST_BIT];
            end
            2'd2: buf_ptr <= mem_rdata[ADDR_W-1:0];
            default: begin
              next_ptr   <= mem_rdata[ADDR_W-1:0];
              byte_left  <= size_q;
              first_pend <= first_q;
              state      <= (size_q == '0) ? ST_CLOSE : ST_RDBUF;
            end
          endcase
        end
        ST_RDBUF: if (mem_ready) begin
          word_buf <= mem_rdata;
          byte_sel <= '0;
          buf_ptr  <= buf_ptr + ADDR_W'(4);
          state    <= ST_PUSH;
        end
        ST_PUSH: if (push_room) begin
          byte_left  <= byte_left - 1'b1;
          first_pend <= 1'b0;
          byte_sel   <= byte_sel + 1'b1;
          if (byte_left == SIZE_W'(1)) begin
            idx   <= '0;
            state <= ST_CLOSE;
          end else if (byte_sel == 2'd3) begin
            state <= ST_RDBUF;
          end
        end
        ST_CLOSE: if (mem_ready) begin
          if (idx == 2'd0) begin
            idx <= 2'd1;
          end else begin
            idx      <= '0;
            cur_addr <= chain_q ? next_ptr : cur_addr + ADDR_W'(DESC_STRIDE);
            state    <= ST_FETCH;
          end
        end
        default: state <= ST_STOP;
      endcase
    end
  end

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FIFO_DEPTH  = 8,
  parameter int DESC_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              poll_req,
  input  logic              flush_req,
  input  logic [ADDR_W-1:0] desc_base,
  output logic [2:0]        dma_state,
  output logic              flush_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last
);

  dma_state_e eng_state;
  logic       push_valid, push_room;
  tx_byte_t   push_byte, pop_byte;

  txdma_desc_engine #(
    .ADDR_W      (ADDR_W),
    .DESC_STRIDE (DESC_STRIDE)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .poll_req   (poll_req),
    .desc_base  (desc_base),
    .state_o    (eng_state),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .push_valid (push_valid),
    .push_byte  (push_byte),
    .push_room  (push_room)
  );

  txdma_byte_fifo #(
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_req),
    .in_valid  (push_valid),
    .in_byte   (push_byte),
    .in_room   (push_room),
    .out_valid (tx_valid),
    .out_byte  (pop_byte),
    .out_ready (tx_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_busy <= 1'b0;
    else        flush_busy <= flush_req;
  end

  assign dma_state = eng_state;
  assign tx_data   = pop_byte.data;
  assign tx_first  = pop_byte.first;
  assign tx_last   = pop_byte.last;

endmodule

// File: rtl/txdesc_dma_checker.sv
module txdesc_dma_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_req,
  input logic              poll_req,
  input logic              flush_req,
  input logic [2:0]        dma_state,
  input logic              flush_busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_first,
  input logic              tx_last
);

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_state == 3'd0 && !start_req) |=> (dma_state == 3'd0));

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_state == 3'd6 && !poll_req) |=> (dma_state == 3'd6));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush_req) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready && mem_wdata[31]) |=>
      (mem_req && mem_we && !mem_wdata[31] && $stable(mem_addr)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (!tx_valid && flush_busy));

endmodule

bind txdesc_dma txdesc_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .poll_req   (poll_req),
  .flush_req  (flush_req),
  .dma_state  (dma_state),
  .flush_busy (flush_busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_first   (tx_first),
  .tx_last    (tx_last)
);

// File: tb/txdesc_dma_test.sv
`timescale 1ns/1ps
module txdesc_dma_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0, poll_req = 1'b0, flush_req = 1'b0;
  logic [31:0] desc_base = 32'h0;
  logic [2:0]  dma_state;
  logic        flush_busy, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_first, tx_last;
  logic [7:0]  tx_data;
  logic        tx_en = 1'b1;

  logic [31:0] mem [256];
  logic [7:0]  lfsr = 8'h5A;

  logic [9:0]  exp_bytes [$];
  logic [31:0] exp_waddr [$];
  logic [31:0] exp_wdata [$];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txdesc_dma uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .poll_req(poll_req),
    .flush_req(flush_req), .desc_base(desc_base), .dma_state(dma_state),
    .flush_busy(flush_busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = lfsr[0] | lfsr[2];
  assign tx_ready  = tx_en & (lfsr[1] | lfsr[4]);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Per-clock comparison of accepted bytes and writes against the model queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_bytes.size() == 0)
          chk(1'b0, "R3", "unexpected byte", {22'b0, tx_first, tx_last, tx_data}, 32'h0);
        else begin
          logic [9:0] e;
          e = exp_bytes.pop_front();
          chk({tx_first, tx_last, tx_data} == e, "R3 R4", "stream byte",
              {22'b0, tx_first, tx_last, tx_data}, {22'b0, e});
        end
      end
      if (mem_req && mem_we && mem_ready) begin
        if (exp_waddr.size() == 0)
          chk(1'b0, "R5", "unexpected write", mem_addr, 32'h0);
        else begin
          logic [31:0] ea, ed;
          ea = exp_waddr.pop_front();
          ed = exp_wdata.pop_front();
          chk(mem_addr == ea, "R5 R6", "write address", mem_addr, ea);
          chk(mem_wdata == ed, "R5", "write data", mem_wdata, ed);
        end
      end
    end
  end

  task automatic put_desc(input int addr, input bit own, input int size,
                          input bit first, input bit last, input bit chain,
                          input int bufa, input int nxt);
    mem[addr >> 2]       = {own, 31'b0};
    mem[(addr >> 2) + 1] = (size & 32'h7FF) | (32'(chain) << 24) | (32'h3 << 27)
                         | (32'(first) << 29) | (32'(last) << 30);
    mem[(addr >> 2) + 2] = bufa;
    mem[(addr >> 2) + 3] = nxt;
  endtask

  task automatic expect_desc(input int addr, input int size, input bit first,
                             input bit last, input int bufa, input bit bytes_out);
    if (bytes_out) begin
      for (int k = 0; k < size; k++) begin
        int a;
        logic [7:0] b;
        a = bufa + k;
        b = mem[a >> 2][8 * (a & 3) +: 8];
        exp_bytes.push_back({first && (k == 0), last && (k == size - 1), b});
      end
    end
    exp_waddr.push_back(addr);
    exp_wdata.push_back(32'h8000_0000 | size);
    exp_waddr.push_back(addr);
    exp_wdata.push_back(size);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
  endtask

  task automatic pulse_poll();
    @(posedge clk); #1 poll_req = 1'b1;
    @(posedge clk); #1 poll_req = 1'b0;
  endtask

  task automatic wait_susp(input string req);
    int n = 0;
    @(negedge clk);
    while (dma_state != 3'd6 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(dma_state == 3'd6, req, "suspended state", {29'b0, dma_state}, 32'd6);
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while ((exp_bytes.size() != 0 || exp_waddr.size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_bytes.size() == 0, req, "bytes left", exp_bytes.size(), 0);
    chk(exp_waddr.size() == 0, req, "writes left", exp_waddr.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64) ? (32'h9E37_79B9 * i) : 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state and staying stopped
    @(negedge clk);
    chk(dma_state == 3'd0, "R1", "state after reset", {29'b0, dma_state}, 0);
    chk(!mem_req && !tx_valid && !flush_busy, "R1", "idle outputs",
        {mem_req, tx_valid, flush_busy}, 0);
    repeat (6) @(negedge clk);
    chk(dma_state == 3'd0 && !mem_req, "R1", "still stopped", {29'b0, dma_state}, 0);

    // R2: start finds a descriptor software owns
    put_desc(32'h000, 1'b0, 7, 1'b1, 1'b1, 1'b1, 32'h100, 32'h000);
    pulse_start();
    wait_susp("R2");
    repeat (5) @(negedge clk);
    chk(!mem_req && !tx_valid, "R2", "nothing after own=0", {mem_req, tx_valid}, 0);
    chk(mem[0] == 32'h0, "R2", "descriptor untouched", mem[0], 0);

    // R7 R6: poll refetches, self link brings the engine back to the same slot
    put_desc(32'h000, 1'b1, 7, 1'b1, 1'b1, 1'b1, 32'h100, 32'h000);
    expect_desc(32'h000, 7, 1'b1, 1'b1, 32'h100, 1'b1);
    pulse_poll();
    wait_susp("R7");
    wait_drain("R3");
    chk(mem[0] == 32'd7, "R5", "released status", mem[0], 7);

    // R6 R8: linked then sequential descriptors; start and poll while running
    put_desc(32'h000, 1'b1, 5, 1'b1, 1'b0, 1'b1, 32'h120, 32'h040);
    put_desc(32'h040, 1'b1, 4, 1'b0, 1'b1, 1'b0, 32'h141, 32'h000);
    mem[32'h140 >> 2] = 32'hA1B2_C3D4;
    put_desc(32'h050, 1'b0, 0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    expect_desc(32'h000, 5, 1'b1, 1'b0, 32'h120, 1'b1);
    mem[32'h141 >> 2] = mem[32'h141 >> 2];
    put_desc(32'h040, 1'b1, 4, 1'b0, 1'b1, 1'b0, 32'h140, 32'h000);
    expect_desc(32'h040, 4, 1'b0, 1'b1, 32'h140, 1'b1);
    pulse_poll();
    repeat (3) @(posedge clk);
    pulse_start();
    pulse_poll();
    wait_susp("R8");
    wait_drain("R8");
    chk(mem[32'h050 >> 2] == 32'h0, "R6", "next slot not released", mem[20], 0);

    // R8: start while suspended
    pulse_start();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dma_state != 3'd6 || mem_req)
        chk(1'b0, "R8", "start in suspend", {28'b0, mem_req, dma_state}, 32'd6);
    end
    chk(dma_state == 3'd6, "R8", "still suspended", {29'b0, dma_state}, 6);

    // R9: zero-size descriptor
    put_desc(32'h050, 1'b1, 0, 1'b1, 1'b1, 1'b0, 32'h180, 32'h0);
    put_desc(32'h060, 1'b0, 0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    expect_desc(32'h050, 0, 1'b1, 1'b1, 32'h180, 1'b1);
    pulse_poll();
    wait_susp("R9");
    wait_drain("R9");
    chk(mem[32'h050 >> 2] == 32'h0, "R9", "zero-size release", mem[20], 0);

    // R10: flush drops bytes that the stalled consumer has not taken
    tx_en = 1'b0;
    put_desc(32'h060, 1'b1, 6, 1'b1, 1'b1, 1'b0, 32'h160, 32'h0);
    put_desc(32'h070, 1'b0, 0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    expect_desc(32'h060, 6, 1'b1, 1'b1, 32'h160, 1'b0);
    pulse_poll();
    wait_susp("R10");
    wait_drain("R10");
    chk(tx_valid == 1'b1, "R10", "bytes held before flush", tx_valid, 1);
    @(posedge clk); #1 flush_req = 1'b1;
    @(posedge clk); #1 flush_req = 1'b0;
    @(negedge clk);
    chk(flush_busy == 1'b1, "R10", "busy after flush", flush_busy, 1);
    chk(tx_valid == 1'b0, "R10", "queue empty after flush", tx_valid, 0);
    @(negedge clk);
    chk(flush_busy == 1'b0, "R10", "busy clears", flush_busy, 0);
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(tx_valid == 1'b0, "R10", "no byte after flush", tx_valid, 0);

    summary();
  end

endmodule